// File: doc/BRIEF.md
# Minimal Stored-Program 8-bit Processor

This block is a small processor core that fetches, decodes and executes fixed 16-bit instructions. Program and data share one 256-byte, byte-addressed memory outside the block. The core reaches that memory through a synchronous port with one cycle of read latency. Inside the core are sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register.

Every instruction splits into four 4-bit fields: opcode in bits 15:12, then fields in bits 11:8, 7:4 and 3:0, with bits 7:0 also read as an 8-bit immediate or address. A write to register 15 also appears on a character output with a one-cycle strobe, so a program can print. Execution runs until a halt instruction or an undefined opcode, and the core then holds still until reset.

Top module: `sp8_core`

## Requirements
- R1: Synchronous active-low reset clears all registers and the program counter to 0 and drives halted, illegal, out_valid and mem_we low. In the first cycle after reset is released, mem_addr is 0.
- R2: Fetch takes three cycles. The first drives mem_addr = PC and the second drives PC+1. The byte at PC is bits 15:12..8 of the instruction (the high byte) and the byte at PC+1 is the low byte. The PC then advances by 2. The fourth cycle executes, so an instruction takes 4 cycles; a memory load takes 5 and a rotate takes 5+X.
- R3: Opcode 0x1 loads register R (bits 11:8) from memory address bits 7:0. Opcode 0x2 loads the immediate in bits 7:0 into R. Opcode 0x3 writes R to address bits 7:0, with mem_we high in the fourth cycle of the instruction.
- R4: Opcode 0x4 copies the register named in bits 7:4 into the register named in bits 3:0.
- R5: Opcodes 0x5, 0x7, 0x8 and 0x9 write to R (bits 11:8) the modulo-256 sum, OR, AND and XOR of the registers named in bits 7:4 and 3:0.
- R6: Opcode 0xA rotates R right X times, where X is bits 3:0, with the least significant bit entering the most significant position. One step is taken per cycle, and X = 0 leaves R unchanged.
- R7: Opcode 0xB loads bits 7:0 into the PC when R equals register 0; otherwise execution continues at the next instruction.
- R8: Every write to register 15 raises out_valid for exactly the one cycle after the write, with out_char holding the written value.
- R9: Opcode 0xC, whatever its low 12 bits, halts the core. From the cycle after its execute cycle, halted stays high until reset and no memory write or output strobe occurs.
- R10: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF halt the core as in R9 and also raise illegal, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data for the address presented in the previous cycle |
| out_valid | output | 1 | One-cycle strobe for a write to register 15 |
| out_char | output | 8 | Value last written to register 15 |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
The assertions assume that reset is held low for at least one clock edge before the core runs. They also assume that mem_rdata always returns the byte stored at the previous cycle's address, so that fetches and loads see real program bytes. The bench meets these assumptions with a behavioural one-cycle-latency memory. That memory is loaded only while reset is held, and it then takes writes only from the core. Every program in the bench ends in a halt or an undefined opcode, so the checks of the stopped state are always reached.

// File: rtl/sp8_pkg.sv
// Shared constants, opcode and state encodings for the 8-bit stored-program core.
// Assumes a 16-bit instruction made of four 4-bit fields.
package sp8_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int REG_CNT = 16;
    localparam int INSN_W  = 16;
    localparam int FLD_W   = 4;

    typedef enum logic [3:0] {
        OP_LDM = 4'h1,
        OP_LDI = 4'h2,
        OP_STM = 4'h3,
        OP_MOV = 4'h4,
        OP_ADD = 4'h5,
        OP_OR  = 4'h7,
        OP_AND = 4'h8,
        OP_XOR = 4'h9,
        OP_ROR = 4'hA,
        OP_JEQ = 4'hB,
        OP_HLT = 4'hC
    } opcode_e;

    typedef enum logic [2:0] {
        ST_F0, ST_F1, ST_F2, ST_EX, ST_LW, ST_RT, ST_HL
    } state_e;

    // One-bit right rotation of a data word.
    function automatic logic [DATA_W-1:0] rotr1(input logic [DATA_W-1:0] v);
        return {v[0], v[DATA_W-1:1]};
    endfunction

    // True for every opcode the core implements, including halt.
    function automatic logic op_known(input logic [3:0] op);
        case (op)
            OP_LDM, OP_LDI, OP_STM, OP_MOV, OP_ADD, OP_OR, OP_AND,
            OP_XOR, OP_ROR, OP_JEQ, OP_HLT: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sp8_regfile.sv
// General register file: NREG words, three read ports, one write port,
// plus a dedicated read of register 0 for the compare-and-jump.
// Assumes one write per cycle; reads are combinational.
module sp8_regfile import sp8_pkg::*; #(
    parameter int DW   = DATA_W,
    parameter int NREG = REG_CNT,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    input  logic [IW-1:0] ra_c,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c,
    output logic [DW-1:0] rd_zero
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Register g: cleared on reset, loaded when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == IW'(g))
                regs[g] <= wdata;
        end
    end

    assign rd_a    = regs[ra_a];
    assign rd_b    = regs[ra_b];
    assign rd_c    = regs[ra_c];
    assign rd_zero = regs[0];
endmodule

// File: rtl/sp8_alu.sv
// Two-operand arithmetic and logic unit: sum, OR, AND, XOR selected by opcode.
// Assumes the caller only uses the result for the matching opcodes.
module sp8_alu import sp8_pkg::*; #(
    parameter int DW = DATA_W
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    // Select the operation named by the opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/sp8_ctrl.sv
// Control unit: program counter, instruction register and the
// fetch/decode/execute state machine, plus the rotate sequencer.
// Assumes memory read data arrives one cycle after its address.
module sp8_ctrl import sp8_pkg::*; #(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NREG = REG_CNT,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [3:0]    opc,
    output logic [IW-1:0] fld_r,
    output logic [IW-1:0] fld_s,
    output logic [IW-1:0] fld_t,
    input  logic [DW-1:0] rd_r,
    input  logic [DW-1:0] rd_s,
    input  logic [DW-1:0] rd_zero,
    input  logic [DW-1:0] alu_y,
    output logic          rf_we,
    output logic [IW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic          halted,
    output logic          illegal
);
    state_e             st, st_nx;
    logic [AW-1:0]      pc;
    logic [INSN_W-1:0]  ir;
    logic [DW-1:0]      rot_v;
    logic [FLD_W-1:0]   rot_n;
    logic [7:0]         imm;

    assign opc   = ir[15:12];
    assign fld_r = ir[11:8];
    assign fld_s = ir[7:4];
    assign fld_t = ir[3:0];
    assign imm   = ir[7:0];

    // Next state, memory port and register write port for the current state.
    always_comb begin
        st_nx     = st;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = rd_r;
        rf_we     = 1'b0;
        rf_waddr  = fld_r;
        rf_wdata  = alu_y;
        case (st)
            ST_F0: st_nx = ST_F1;
            ST_F1: begin
                mem_addr = pc + AW'(1);
                st_nx    = ST_F2;
            end
            ST_F2: st_nx = ST_EX;
            ST_EX: begin
                case (opc)
                    OP_LDM: begin
                        mem_addr = AW'(imm);
                        st_nx    = ST_LW;
                    end
                    OP_LDI: begin
                        rf_we    = 1'b1;
                        rf_wdata = imm;
                        st_nx    = ST_F0;
                    end
                    OP_STM: begin
                        mem_we   = 1'b1;
                        mem_addr = AW'(imm);
                        st_nx    = ST_F0;
                    end
                    OP_MOV: begin
                        rf_we    = 1'b1;
                        rf_waddr = fld_t;
                        rf_wdata = rd_s;
                        st_nx    = ST_F0;
                    end
                    OP_ADD, OP_OR, OP_AND, OP_XOR: begin
                        rf_we = 1'b1;
                        st_nx = ST_F0;
                    end
                    OP_ROR:  st_nx = ST_RT;
                    OP_JEQ:  st_nx = ST_F0;
                    default: st_nx = ST_HL;
                endcase
            end
            ST_LW: begin
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
                st_nx    = ST_F0;
            end
            ST_RT: begin
                if (rot_n == '0) begin
                    rf_we    = 1'b1;
                    rf_wdata = rot_v;
                    st_nx    = ST_F0;
                end
            end
            default: st_nx = ST_HL;
        endcase
    end

    // State, PC, instruction register, rotate sequencer and stop flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_F0;
            pc      <= '0;
            ir      <= '0;
            rot_v   <= '0;
            rot_n   <= '0;
            halted  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            st <= st_nx;
            case (st)
                ST_F1: ir[15:8] <= mem_rdata;
                ST_F2: begin
                    ir[7:0] <= mem_rdata;
                    pc      <= pc + AW'(2);
                end
                ST_EX: begin
                    if (opc == OP_JEQ && rd_r == rd_zero)
                        pc <= AW'(imm);
                    if (opc == OP_ROR) begin
                        rot_v <= rd_r;
                        rot_n <= ir[3:0];
                    end
                    if (st_nx == ST_HL) begin
                        halted  <= 1'b1;
                        illegal <= !op_known(opc);
                    end
                end
                ST_RT: begin
                    if (rot_n != '0) begin
                        rot_v <= rotr1(rot_v);
                        rot_n <= rot_n - FLD_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sp8_core.sv
// Top of the stored-program core: joins control, register file and ALU,
// and registers the character output fed by writes to the last register.
// Assumes an external synchronous byte memory with one-cycle read latency.
module sp8_core import sp8_pkg::*; #(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int NREG = REG_CNT,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [DW-1:0] out_char,
    output logic          halted,
    output logic          illegal
);
    logic [3:0]    opc;
    logic [IW-1:0] fld_r, fld_s, fld_t, rf_waddr;
    logic [DW-1:0] rd_r, rd_s, rd_t, rd_zero, alu_y, rf_wdata;
    logic          rf_we;

    sp8_ctrl #(.DW(DW), .AW(AW), .NREG(NREG)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .opc(opc), .fld_r(fld_r), .fld_s(fld_s), .fld_t(fld_t),
        .rd_r(rd_r), .rd_s(rd_s), .rd_zero(rd_zero), .alu_y(alu_y),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .halted(halted), .illegal(illegal)
    );

    sp8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .ra_a(fld_r), .ra_b(fld_s), .ra_c(fld_t),
        .rd_a(rd_r), .rd_b(rd_s), .rd_c(rd_t), .rd_zero(rd_zero)
    );

    sp8_alu #(.DW(DW)) u_alu (
        .op(opc), .a(rd_s), .b(rd_t), .y(alu_y)
    );

    // Character output: strobe and capture on any write to the last register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= rf_we && (rf_waddr == IW'(NREG - 1));
            if (rf_we && (rf_waddr == IW'(NREG - 1)))
                out_char <= rf_wdata;
        end
    end
endmodule

// File: rtl/sp8_core_chk.sv
// Property checker for sp8_core, attached by bind. Observes ports only.
// Assumes reset is low for at least one clock edge before running.
module sp8_core_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          out_valid,
    input logic          halted,
    input logic          illegal
);
    assert_first_fetch_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> mem_addr == '0);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !out_valid));

    assert_halt_addr_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(mem_addr));

    assert_illegal_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    assert_illegal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

bind sp8_core sp8_core_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .out_valid(out_valid), .halted(halted), .illegal(illegal)
);

// File: tb/sp8_core_test.sv
// Bench for sp8_core: a behavioural memory plus an instruction-level
// reference interpreter that predicts the ports on every clock.
module sp8_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, out_char;
    logic [7:0] mem_rdata;
    logic       mem_we, out_valid, halted, illegal;

    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;
    logic [7:0] mem [256];
    logic [7:0] mm  [256];
    logic [7:0] mr  [16];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    sp8_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_char(out_char), .halted(halted), .illegal(illegal)
    );

    // Synchronous byte memory, one-cycle read latency, loaded during reset.
    always @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9 watchdog: no halt", 0, 1);
        finish_up();
    end

    task automatic clear_model();
        for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mm[a] = w[15:8];
        mm[a + 1] = w[7:0];
    endtask

    // Hold reset, copy the model memory into the bench memory, check reset state.
    task automatic start();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = mm[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        repeat (2) @(negedge clk);
        chk(halted == 1'b0, "R1 halted after reset", halted, 0);
        chk(illegal == 1'b0, "R1 illegal after reset", illegal, 0);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(mem_we == 1'b0, "R1 mem_we after reset", mem_we, 0);
        rst_n = 1'b1;
        chk(mem_addr == 8'h00, "R1 first fetch address", mem_addr, 0);
    endtask

    // Interpret the program in mm, compare the ports every cycle.
    task automatic run_prog(input string ptag);
        logic [7:0] pc, hi, lo, nv, sv, sa, v, npc, pval;
        logic [3:0] op, r, s, t, dst;
        int n, steps, mis;
        bit wr, st, hlt, ill, pend;
        for (int i = 0; i < 16; i++) mr[i] = 8'h00;
        pc = 8'h00; pend = 1'b0; pval = 8'h00; hlt = 1'b0; ill = 1'b0; steps = 0;
        while (!hlt && steps < 400) begin
            steps++;
            hi = mm[pc]; lo = mm[pc + 8'd1];
            op = hi[7:4]; r = hi[3:0]; s = lo[7:4]; t = lo[3:0];
            n = 4; wr = 1'b0; st = 1'b0; ill = 1'b0; dst = r; nv = 8'h00;
            sv = mr[r]; sa = lo; npc = pc + 8'd2;
            case (op)
                4'h1: begin n = 5; wr = 1'b1; nv = mm[lo]; end
                4'h2: begin wr = 1'b1; nv = lo; end
                4'h3: st = 1'b1;
                4'h4: begin wr = 1'b1; dst = t; nv = mr[s]; end
                4'h5: begin wr = 1'b1; nv = mr[s] + mr[t]; end
                4'h7: begin wr = 1'b1; nv = mr[s] | mr[t]; end
                4'h8: begin wr = 1'b1; nv = mr[s] & mr[t]; end
                4'h9: begin wr = 1'b1; nv = mr[s] ^ mr[t]; end
                4'hA: begin
                    n = 5 + int'(t); wr = 1'b1; v = mr[r];
                    for (int j = 0; j < int'(t); j++) v = {v[0], v[7:1]};
                    nv = v;
                end
                4'hB: if (mr[r] == mr[0]) npc = lo;
                4'hC: hlt = 1'b1;
                default: begin hlt = 1'b1; ill = 1'b1; end
            endcase
            for (int k = 0; k < n; k++) begin
                if (k == 0) begin
                    chk(out_valid == pend, {"R8 strobe ", ptag}, out_valid, pend);
                    if (pend) chk(out_char == pval, {"R8 char ", ptag}, out_char, pval);
                    chk(mem_addr == pc, {"R2 R7 high byte address ", ptag}, mem_addr, pc);
                end else begin
                    chk(out_valid == 1'b0, {"R8 strobe idle ", ptag}, out_valid, 0);
                end
                if (k == 1)
                    chk(mem_addr == pc + 8'd1, {"R2 low byte address ", ptag}, mem_addr, pc + 8'd1);
                if (k == 3 && st) begin
                    chk(mem_we == 1'b1, {"R3 store enable ", ptag}, mem_we, 1);
                    chk(mem_addr == sa, {"R3 store address ", ptag}, mem_addr, sa);
                    chk(mem_wdata == sv, {"R3 store data ", ptag}, mem_wdata, sv);
                end else begin
                    chk(mem_we == 1'b0, {"R3 no write ", ptag}, mem_we, 0);
                end
                if (k == 3 && op == 4'h1)
                    chk(mem_addr == lo, {"R3 load address ", ptag}, mem_addr, lo);
                chk(halted == 1'b0, {"R9 running ", ptag}, halted, 0);
                @(negedge clk);
            end
            if (wr) mr[dst] = nv;
            if (st) mm[sa] = sv;
            pend = wr && (dst == 4'hF);
            pval = nv;
            pc = npc;
        end
        chk(hlt, {"R9 program reached halt ", ptag}, steps, 0);
        for (int k = 0; k < 4; k++) begin
            chk(halted == 1'b1, {"R9 halted ", ptag}, halted, 1);
            chk(illegal == ill, {"R10 illegal flag ", ptag}, illegal, ill);
            chk(mem_we == 1'b0, {"R9 no write after halt ", ptag}, mem_we, 0);
            chk(out_valid == 1'b0, {"R9 no strobe after halt ", ptag}, out_valid, 0);
            @(negedge clk);
        end
        mis = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== mm[i]) mis++;
        chk(mis == 0, {"memory image ", ptag}, mis, 0);
    endtask

    initial begin
        // Counting loop: jump taken and not taken, strobes 0..5.
        clear_model();
        put(8'h00, 16'h2005);
        put(8'h02, 16'h2F00);
        put(8'h04, 16'h2701);
        put(8'h06, 16'h5FF7);
        put(8'h08, 16'hBF0C);
        put(8'h0A, 16'hB006);
        put(8'h0C, 16'hC000);
        start();
        run_prog("R7 R8 count loop");

        // Data path: loads, logic ops, add wrap, moves, rotates, stores.
        clear_model();
        mm[8'h80] = 8'h9A; mm[8'h81] = 8'hC9; mm[8'h82] = 8'hAB;
        mm[8'h83] = 8'hF0; mm[8'h84] = 8'h20;
        put(8'h00, 16'h1180);
        put(8'h02, 16'h1281);
        put(8'h04, 16'h7312);
        put(8'h06, 16'h8412);
        put(8'h08, 16'h9512);
        put(8'h0A, 16'h3390);
        put(8'h0C, 16'h3491);
        put(8'h0E, 16'h3592);
        put(8'h10, 16'h1682);
        put(8'h12, 16'hA601);
        put(8'h14, 16'h3693);
        put(8'h16, 16'h4067);
        put(8'h18, 16'hA709);
        put(8'h1A, 16'h3794);
        put(8'h1C, 16'h1883);
        put(8'h1E, 16'hA800);
        put(8'h20, 16'h3895);
        put(8'h22, 16'h1984);
        put(8'h24, 16'h5A89);
        put(8'h26, 16'h3A96);
        put(8'h28, 16'h40AF);
        put(8'h2A, 16'h3C97);
        put(8'h2C, 16'h2F41);
        put(8'h2E, 16'h1F80);
        put(8'h30, 16'hAF03);
        put(8'h32, 16'h3F98);
        put(8'h34, 16'hC000);
        start();
        run_prog("R1 R3 R4 R5 R6 data path");

        // Halt with nonzero operand bits is still a plain halt.
        clear_model();
        put(8'h00, 16'h2F07);
        put(8'h02, 16'hC123);
        put(8'h04, 16'h3F90);
        start();
        run_prog("R9 halt operands");

        // Each undefined opcode stops the core and flags it; later store skipped.
        for (int q = 0; q < 5; q++) begin
            logic [3:0] bad;
            bad = (q == 0) ? 4'h0 : (q == 1) ? 4'h6 : (q == 2) ? 4'hD : (q == 3) ? 4'hE : 4'hF;
            clear_model();
            put(8'h00, {8'h2F, 4'h0, bad});
            put(8'h02, {bad, 12'h390});
            put(8'h04, 16'h3F90);
            start();
            run_prog("R10 undefined opcode");
        end
        finish_up();
    end
endmodule